// File: doc/BRIEF.md
# Class-Partitioned Reservation Station Pool

This block holds instructions between in-order issue and out-of-order execution. It is split into two groups: ALU slots and load slots. When an instruction is issued, the pool places it in a free slot of its class. The slot keeps the opcode and the reorder-buffer tag that will label the result. Each of the two source operands arrives either as a value or as the tag of the instruction that will produce it. A slot that still waits on a tag watches the result broadcast bus. It takes the value when a broadcast with a matching tag appears.

Each group has one dispatch port. When its functional unit is free, the group offers the oldest slot that has both operands. That slot is released on the same clock edge. Each group reports when it is full, so the issue stage can stall. A flush input clears the whole pool at once, for example when a taken branch commits.

Each slot is a three-state machine:
- `SLOT_FREE`: the slot holds nothing.
- `SLOT_WAIT`: the slot holds an instruction that still lacks at least one operand.
- `SLOT_READY`: the slot holds an instruction with both operands.

The transitions are:
- free-to-wait: allocation while an operand is still missing.
- free-to-ready: allocation with both operands present, counting any captured from the bus in that cycle.
- wait-to-ready: the last missing operand is captured from the bus.
- ready-to-free: the slot is dispatched.
- any-to-free: flush.

Top module: `rs_pool`

## Requirements
- R1: After reset, every slot is free: `alu_full` and `ld_full` are 0, and `alu_go` and `ld_go` stay 0 even when the units are free.
- R2: `alloc_cls` selects the group: 0 for ALU, 1 for load. An allocation only fills a slot of its own group. A group's full output is 1 exactly when all of that group's slots (`ALU_N` or `LD_N`) are occupied.
- R3: An operand marked ready at allocation is stored as the given value. A slot whose operands are both ready can be dispatched from the next cycle. It is then presented with its opcode, destination tag and both values.
- R4: An operand not ready at allocation keeps its producer tag. The slot takes the value from the first broadcast whose tag matches and can be dispatched from the following cycle. A broadcast with any other tag leaves the slot waiting.
- R5: A broadcast in the same cycle as an allocation is matched against the incoming operand tags and captured at once.
- R6: A group dispatches only when its functional-unit-free input is 1 and it holds a slot with both operands.
- R7: When several slots of a group can be dispatched, the one allocated earliest goes first, whatever its slot position.
- R8: A dispatched slot is freed on the same clock edge. If that group gets no allocation in that cycle, its full output is 0 in the next cycle.
- R9: An allocation to a full group is ignored. The full output stays 1 until a dispatch or flush, and no occupied slot is overwritten.
- R10: While `flush` is 1, nothing is dispatched and an allocation in that cycle is dropped. In the next cycle every slot is free.
- R11: A broadcast whose tag matches an operand that is already valid leaves that operand's value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Clear all slots |
| alloc_valid | input | 1 | Allocation request |
| alloc_cls | input | 1 | Class of request: 0 ALU, 1 load |
| alloc_op | input | OP_W | Opcode |
| alloc_dst | input | TAG_W | Reorder-buffer tag of the result |
| alloc_a_rdy | input | 1 | Operand A is supplied as a value |
| alloc_a_val | input | DATA_W | Operand A value |
| alloc_a_tag | input | TAG_W | Operand A producer tag |
| alloc_b_rdy | input | 1 | Operand B is supplied as a value |
| alloc_b_val | input | DATA_W | Operand B value |
| alloc_b_tag | input | TAG_W | Operand B producer tag |
| bc_valid | input | 1 | Broadcast bus carries a result |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| alu_fu_free | input | 1 | ALU unit can accept an operation |
| ld_fu_free | input | 1 | Load unit can accept an operation |
| alu_full | output | 1 | All ALU slots occupied |
| ld_full | output | 1 | All load slots occupied |
| alu_go | output | 1 | ALU dispatch this cycle |
| alu_go_op | output | OP_W | Dispatched ALU opcode |
| alu_go_dst | output | TAG_W | Dispatched ALU destination tag |
| alu_go_a | output | DATA_W | Dispatched ALU operand A |
| alu_go_b | output | DATA_W | Dispatched ALU operand B |
| ld_go | output | 1 | Load dispatch this cycle |
| ld_go_op | output | OP_W | Dispatched load opcode |
| ld_go_dst | output | TAG_W | Dispatched load destination tag |
| ld_go_a | output | DATA_W | Dispatched load operand A |
| ld_go_b | output | DATA_W | Dispatched load operand B |

## Verification
The bench builds the pool with two slots per group, 3-bit tags, a 4-bit opcode and 16-bit data. With two slots, filling a group takes two allocations. Freeing the lower slot and refilling it puts a younger instruction below an older one, so age order and slot position disagree. Eight tag values let matching and non-matching broadcasts be tried side by side, and 16-bit data keeps the captured values easy to tell apart.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE,
        SLOT_WAIT,
        SLOT_READY
    } slot_state_e;

    localparam logic CLS_ALU  = 1'b0;
    localparam logic CLS_LOAD = 1'b1;

endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pool_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc,
    input  logic              take,
    input  logic [OP_W-1:0]   in_op,
    input  logic [TAG_W-1:0]  in_dst,
    input  logic              in_a_rdy,
    input  logic [DATA_W-1:0] in_a_val,
    input  logic [TAG_W-1:0]  in_a_tag,
    input  logic              in_b_rdy,
    input  logic [DATA_W-1:0] in_b_val,
    input  logic [TAG_W-1:0]  in_b_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   out_op,
    output logic [TAG_W-1:0]  out_dst,
    output logic [DATA_W-1:0] out_a,
    output logic [DATA_W-1:0] out_b
);

    slot_state_e       state_q, state_d;
    logic [OP_W-1:0]   op_q;
    logic [TAG_W-1:0]  dst_q;
    logic              a_ok_q, b_ok_q;
    logic [DATA_W-1:0] a_val_q, b_val_q;
    logic [TAG_W-1:0]  a_tag_q, b_tag_q;

    // Operand status for an allocation arriving this cycle (same-cycle capture)
    logic a_ok_new, b_ok_new;
    // Wakeup of an operand that is already held
    logic a_hit_old, b_hit_old;

    always_comb begin
        a_ok_new  = in_a_rdy || (bc_valid && bc_tag == in_a_tag);
        b_ok_new  = in_b_rdy || (bc_valid && bc_tag == in_b_tag);
        a_hit_old = !a_ok_q && bc_valid && bc_tag == a_tag_q;
        b_hit_old = !b_ok_q && bc_valid && bc_tag == b_tag_q;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: begin
                if (alloc) state_d = (a_ok_new && b_ok_new) ? SLOT_READY : SLOT_WAIT;
            end
            SLOT_WAIT: begin
                if ((a_ok_q || a_hit_old) && (b_ok_q || b_hit_old)) state_d = SLOT_READY;
            end
            SLOT_READY: begin
                if (take) state_d = SLOT_FREE;
            end
            default: state_d = SLOT_FREE;
        endcase
        if (flush) state_d = SLOT_FREE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    // Payload capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_ok_q <= 1'b0;
            b_ok_q <= 1'b0;
        end else if (state_q == SLOT_FREE && alloc) begin
            op_q    <= in_op;
            dst_q   <= in_dst;
            a_ok_q  <= a_ok_new;
            b_ok_q  <= b_ok_new;
            a_tag_q <= in_a_tag;
            b_tag_q <= in_b_tag;
            a_val_q <= in_a_rdy ? in_a_val : bc_val;
            b_val_q <= in_b_rdy ? in_b_val : bc_val;
        end else if (state_q == SLOT_WAIT) begin
            if (a_hit_old) begin
                a_ok_q  <= 1'b1;
                a_val_q <= bc_val;
            end
            if (b_hit_old) begin
                b_ok_q  <= 1'b1;
                b_val_q <= bc_val;
            end
        end
    end

    // Outputs
    always_comb begin
        busy    = (state_q != SLOT_FREE);
        ready   = (state_q == SLOT_READY);
        out_op  = op_q;
        out_dst = dst_q;
        out_a   = a_val_q;
        out_b   = b_val_q;
    end

endmodule

// File: rtl/rs_group.sv
module rs_group #(
    parameter int N      = 2,
    parameter int OP_W   = 4,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_en,
    input  logic [OP_W-1:0]   in_op,
    input  logic [TAG_W-1:0]  in_dst,
    input  logic              in_a_rdy,
    input  logic [DATA_W-1:0] in_a_val,
    input  logic [TAG_W-1:0]  in_a_tag,
    input  logic              in_b_rdy,
    input  logic [DATA_W-1:0] in_b_val,
    input  logic [TAG_W-1:0]  in_b_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    input  logic              fu_free,
    output logic              full,
    output logic              go,
    output logic [OP_W-1:0]   go_op,
    output logic [TAG_W-1:0]  go_dst,
    output logic [DATA_W-1:0] go_a,
    output logic [DATA_W-1:0] go_b
);

    logic [N-1:0]      busy, ready, alloc_sel, take;
    logic [OP_W-1:0]   s_op  [N];
    logic [TAG_W-1:0]  s_dst [N];
    logic [DATA_W-1:0] s_a   [N];
    logic [DATA_W-1:0] s_b   [N];
    // older_q[i][j] set: slot i was allocated before slot j
    logic [N-1:0][N-1:0] older_q;

    for (genvar g = 0; g < N; g++) begin : g_slot
        rs_slot #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .flush(flush),
            .alloc(alloc_sel[g]), .take(take[g]),
            .in_op(in_op), .in_dst(in_dst),
            .in_a_rdy(in_a_rdy), .in_a_val(in_a_val), .in_a_tag(in_a_tag),
            .in_b_rdy(in_b_rdy), .in_b_val(in_b_val), .in_b_tag(in_b_tag),
            .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
            .busy(busy[g]), .ready(ready[g]),
            .out_op(s_op[g]), .out_dst(s_dst[g]), .out_a(s_a[g]), .out_b(s_b[g])
        );
    end

    // Lowest free slot receives the allocation
    always_comb begin
        logic found;
        found     = 1'b0;
        alloc_sel = '0;
        for (int i = 0; i < N; i++) begin
            if (!busy[i] && !found) begin
                alloc_sel[i] = alloc_en;
                found        = 1'b1;
            end
        end
        full = &busy;
    end

    // Oldest ready slot is dispatched
    always_comb begin
        logic blocked;
        take = '0;
        for (int i = 0; i < N; i++) begin
            blocked = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != i && ready[j] && older_q[j][i]) blocked = 1'b1;
            end
            take[i] = ready[i] && fu_free && !flush && !blocked;
        end
    end

    always_comb begin
        go     = |take;
        go_op  = '0;
        go_dst = '0;
        go_a   = '0;
        go_b   = '0;
        for (int i = 0; i < N; i++) begin
            if (take[i]) begin
                go_op  = go_op  | s_op[i];
                go_dst = go_dst | s_dst[i];
                go_a   = go_a   | s_a[i];
                go_b   = go_b   | s_b[i];
            end
        end
    end

    // Age matrix: a new slot is younger than every occupied slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            older_q <= '0;
        end else if (!flush) begin
            for (int j = 0; j < N; j++) begin
                if (alloc_sel[j]) begin
                    for (int i = 0; i < N; i++) begin
                        older_q[i][j] <= (i != j) && busy[i];
                        older_q[j][i] <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rs_pool.sv
module rs_pool
    import rs_pool_pkg::*;
#(
    parameter int ALU_N  = 2,
    parameter int LD_N   = 2,
    parameter int OP_W   = 4,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_valid,
    input  logic              alloc_cls,
    input  logic [OP_W-1:0]   alloc_op,
    input  logic [TAG_W-1:0]  alloc_dst,
    input  logic              alloc_a_rdy,
    input  logic [DATA_W-1:0] alloc_a_val,
    input  logic [TAG_W-1:0]  alloc_a_tag,
    input  logic              alloc_b_rdy,
    input  logic [DATA_W-1:0] alloc_b_val,
    input  logic [TAG_W-1:0]  alloc_b_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_val,
    input  logic              alu_fu_free,
    input  logic              ld_fu_free,
    output logic              alu_full,
    output logic              ld_full,
    output logic              alu_go,
    output logic [OP_W-1:0]   alu_go_op,
    output logic [TAG_W-1:0]  alu_go_dst,
    output logic [DATA_W-1:0] alu_go_a,
    output logic [DATA_W-1:0] alu_go_b,
    output logic              ld_go,
    output logic [OP_W-1:0]   ld_go_op,
    output logic [TAG_W-1:0]  ld_go_dst,
    output logic [DATA_W-1:0] ld_go_a,
    output logic [DATA_W-1:0] ld_go_b
);

    logic alu_req, ld_req;

    always_comb begin
        alu_req = alloc_valid && (alloc_cls == CLS_ALU);
        ld_req  = alloc_valid && (alloc_cls == CLS_LOAD);
    end

    rs_group #(.N(ALU_N), .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_alu (
        .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_en(alu_req),
        .in_op(alloc_op), .in_dst(alloc_dst),
        .in_a_rdy(alloc_a_rdy), .in_a_val(alloc_a_val), .in_a_tag(alloc_a_tag),
        .in_b_rdy(alloc_b_rdy), .in_b_val(alloc_b_val), .in_b_tag(alloc_b_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
        .fu_free(alu_fu_free), .full(alu_full), .go(alu_go),
        .go_op(alu_go_op), .go_dst(alu_go_dst), .go_a(alu_go_a), .go_b(alu_go_b)
    );

    rs_group #(.N(LD_N), .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_ld (
        .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_en(ld_req),
        .in_op(alloc_op), .in_dst(alloc_dst),
        .in_a_rdy(alloc_a_rdy), .in_a_val(alloc_a_val), .in_a_tag(alloc_a_tag),
        .in_b_rdy(alloc_b_rdy), .in_b_val(alloc_b_val), .in_b_tag(alloc_b_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
        .fu_free(ld_fu_free), .full(ld_full), .go(ld_go),
        .go_op(ld_go_op), .go_dst(ld_go_dst), .go_a(ld_go_a), .go_b(ld_go_b)
    );

endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk
    import rs_pool_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic flush,
    input logic alloc_valid,
    input logic alloc_cls,
    input logic alu_fu_free,
    input logic ld_fu_free,
    input logic alu_full,
    input logic ld_full,
    input logic alu_go,
    input logic ld_go
);

    // R6
    alu_go_needs_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alu_go |-> alu_fu_free);

    // R6
    ld_go_needs_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_go |-> ld_fu_free);

    // R10
    flush_no_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!alu_go && !ld_go));

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!alu_full && !ld_full && !alu_go && !ld_go));

    // R9
    alu_full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_full && !alu_go && !flush) |=> alu_full);

    // R9
    ld_full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_full && !ld_go && !flush) |=> ld_full);

    // R8
    alu_freed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_go && !flush && !(alloc_valid && alloc_cls == CLS_ALU)) |=> !alu_full);

    // R8
    ld_freed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_go && !flush && !(alloc_valid && alloc_cls == CLS_LOAD)) |=> !ld_full);

endmodule

bind rs_pool rs_pool_chk u_chk (.*);

// File: tb/rs_pool_tb.sv
module rs_pool_tb;

    localparam int OP_W = 4;
    localparam int TAG_W = 3;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic              alloc_valid = 1'b0;
    logic              alloc_cls = 1'b0;
    logic [OP_W-1:0]   alloc_op = '0;
    logic [TAG_W-1:0]  alloc_dst = '0;
    logic              alloc_a_rdy = 1'b0;
    logic [DATA_W-1:0] alloc_a_val = '0;
    logic [TAG_W-1:0]  alloc_a_tag = '0;
    logic              alloc_b_rdy = 1'b0;
    logic [DATA_W-1:0] alloc_b_val = '0;
    logic [TAG_W-1:0]  alloc_b_tag = '0;
    logic              bc_valid = 1'b0;
    logic [TAG_W-1:0]  bc_tag = '0;
    logic [DATA_W-1:0] bc_val = '0;
    logic              alu_fu_free = 1'b0;
    logic              ld_fu_free = 1'b0;
    logic              alu_full, ld_full, alu_go, ld_go;
    logic [OP_W-1:0]   alu_go_op, ld_go_op;
    logic [TAG_W-1:0]  alu_go_dst, ld_go_dst;
    logic [DATA_W-1:0] alu_go_a, alu_go_b, ld_go_a, ld_go_b;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    rs_pool #(.ALU_N(2), .LD_N(2), .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_valid(alloc_valid), .alloc_cls(alloc_cls), .alloc_op(alloc_op),
        .alloc_dst(alloc_dst),
        .alloc_a_rdy(alloc_a_rdy), .alloc_a_val(alloc_a_val), .alloc_a_tag(alloc_a_tag),
        .alloc_b_rdy(alloc_b_rdy), .alloc_b_val(alloc_b_val), .alloc_b_tag(alloc_b_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
        .alu_fu_free(alu_fu_free), .ld_fu_free(ld_fu_free),
        .alu_full(alu_full), .ld_full(ld_full),
        .alu_go(alu_go), .alu_go_op(alu_go_op), .alu_go_dst(alu_go_dst),
        .alu_go_a(alu_go_a), .alu_go_b(alu_go_b),
        .ld_go(ld_go), .ld_go_op(ld_go_op), .ld_go_dst(ld_go_dst),
        .ld_go_a(ld_go_a), .ld_go_b(ld_go_b)
    );

    typedef struct packed {
        logic              a_rdy;
        logic [DATA_W-1:0] a_val;
        logic [TAG_W-1:0]  a_tag;
        logic              b_rdy;
        logic [DATA_W-1:0] b_val;
        logic [TAG_W-1:0]  b_tag;
        logic [TAG_W-1:0]  bc_tag;
        logic [DATA_W-1:0] bc_val;
        logic [DATA_W-1:0] exp_a;
        logic [DATA_W-1:0] exp_b;
    } vec_t;

    // Allocate one ALU op, broadcast once, then dispatch and compare operands
    localparam vec_t VECS [4] = '{
        '{1'b1, 16'h1111, 3'd5, 1'b1, 16'h2222, 3'd5, 3'd5, 16'hdead, 16'h1111, 16'h2222},
        '{1'b0, 16'h0000, 3'd3, 1'b1, 16'h0042, 3'd0, 3'd3, 16'h0abc, 16'h0abc, 16'h0042},
        '{1'b1, 16'h0007, 3'd0, 1'b0, 16'h0000, 3'd6, 3'd6, 16'h1234, 16'h0007, 16'h1234},
        '{1'b0, 16'h0000, 3'd2, 1'b0, 16'h0000, 3'd2, 3'd2, 16'h5555, 16'h5555, 16'h5555}
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic do_alloc(input logic cls, input logic [OP_W-1:0] op,
                            input logic ar, input logic [DATA_W-1:0] av, input logic [TAG_W-1:0] at,
                            input logic br, input logic [DATA_W-1:0] bv, input logic [TAG_W-1:0] bt);
        alloc_valid = 1'b1;
        alloc_cls   = cls;
        alloc_op    = op;
        alloc_dst   = op[TAG_W-1:0];
        alloc_a_rdy = ar;
        alloc_a_val = av;
        alloc_a_tag = at;
        alloc_b_rdy = br;
        alloc_b_val = bv;
        alloc_b_tag = bt;
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        alu_fu_free = 1'b1;
        ld_fu_free  = 1'b1;
        #1;
        chk("R1 alu_full in reset", alu_full, 0);
        chk("R1 alu_go in reset", alu_go, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 ld_full after reset", ld_full, 0);
        chk("R1 ld_go after reset", ld_go, 0);
        chk("R1 alu_go after reset", alu_go, 0);
        @(negedge clk);
        alu_fu_free = 1'b0;
        ld_fu_free  = 1'b0;

        // Table walk: R3, R4, R11
        for (int i = 0; i < 4; i++) begin
            do_alloc(1'b0, OP_W'(i + 1), VECS[i].a_rdy, VECS[i].a_val, VECS[i].a_tag,
                     VECS[i].b_rdy, VECS[i].b_val, VECS[i].b_tag);
            bc_valid = 1'b1;
            bc_tag   = VECS[i].bc_tag;
            bc_val   = VECS[i].bc_val;
            @(negedge clk);
            bc_valid    = 1'b0;
            alu_fu_free = 1'b1;
            #1;
            chk("R3/R4 vector go", alu_go, 1);
            chk("R3 vector opcode", alu_go_op, i + 1);
            chk("R3 vector dst", alu_go_dst, i + 1);
            chk("R4/R11 vector operand a", alu_go_a, VECS[i].exp_a);
            chk("R4/R11 vector operand b", alu_go_b, VECS[i].exp_b);
            @(negedge clk);
            alu_fu_free = 1'b0;
        end

        // R5: broadcast in the allocation cycle
        bc_valid = 1'b1;
        bc_tag   = 3'd4;
        bc_val   = 16'h0777;
        do_alloc(1'b0, 4'd9, 1'b0, 16'h0, 3'd4, 1'b1, 16'h0001, 3'd0);
        bc_valid    = 1'b0;
        alu_fu_free = 1'b1;
        #1;
        chk("R5 same-cycle capture go", alu_go, 1);
        chk("R5 same-cycle captured a", alu_go_a, 16'h0777);
        @(negedge clk);
        alu_fu_free = 1'b0;

        // R4: non-matching broadcast keeps the slot waiting
        do_alloc(1'b0, 4'd10, 1'b0, 16'h0, 3'd1, 1'b1, 16'h0003, 3'd0);
        bc_valid = 1'b1;
        bc_tag   = 3'd2;
        bc_val   = 16'hffff;
        @(negedge clk);
        bc_valid    = 1'b0;
        alu_fu_free = 1'b1;
        #1;
        chk("R4 other tag ignored, no go", alu_go, 0);
        @(negedge clk);
        alu_fu_free = 1'b0;
        bc_valid    = 1'b1;
        bc_tag      = 3'd1;
        bc_val      = 16'h0101;
        @(negedge clk);
        bc_valid    = 1'b0;
        alu_fu_free = 1'b1;
        #1;
        chk("R4 matching tag wakes slot", alu_go, 1);
        chk("R4 matching tag value", alu_go_a, 16'h0101);
        @(negedge clk);
        alu_fu_free = 1'b0;

        // R7: younger op placed in the lower slot
        do_alloc(1'b0, 4'd1, 1'b1, 16'h0, 3'd0, 1'b1, 16'h0, 3'd0);
        do_alloc(1'b0, 4'd2, 1'b1, 16'h0, 3'd0, 1'b1, 16'h0, 3'd0);
        alu_fu_free = 1'b1;
        #1;
        chk("R7 first oldest", alu_go_op, 1);
        @(negedge clk);
        alu_fu_free = 1'b0;
        do_alloc(1'b0, 4'd3, 1'b1, 16'h0, 3'd0, 1'b1, 16'h0, 3'd0);
        alu_fu_free = 1'b1;
        #1;
        chk("R7 older upper slot first", alu_go_op, 2);
        @(negedge clk);
        #1;
        chk("R7 younger lower slot next", alu_go_op, 3);
        @(negedge clk);
        alu_fu_free = 1'b0;
        #1;
        chk("R7 group drained", alu_go, 0);

        // R2, R8, R9: fill the ALU group and overflow it
        do_alloc(1'b0, 4'd4, 1'b1, 16'h0004, 3'd0, 1'b1, 16'h0, 3'd0);
        do_alloc(1'b0, 4'd5, 1'b1, 16'h0005, 3'd0, 1'b1, 16'h0, 3'd0);
        #1;
        chk("R2 alu_full after two", alu_full, 1);
        chk("R2 ld_full unaffected", ld_full, 0);
        do_alloc(1'b0, 4'd6, 1'b1, 16'h0006, 3'd0, 1'b1, 16'h0, 3'd0);
        #1;
        chk("R9 alloc to full group ignored", alu_full, 1);
        alu_fu_free = 1'b1;
        #1;
        chk("R9 first held op intact", alu_go_op, 4);
        @(negedge clk);
        #1;
        chk("R8 full drops after dispatch", alu_full, 0);
        chk("R9 second held op intact", alu_go_op, 5);
        @(negedge clk);
        #1;
        chk("R9 dropped op never entered", alu_go, 0);
        alu_fu_free = 1'b0;

        // R2: load group
        do_alloc(1'b1, 4'd7, 1'b1, 16'h0700, 3'd0, 1'b1, 16'h0, 3'd0);
        #1;
        chk("R2 one load not full", ld_full, 0);
        chk("R2 load not in ALU group", alu_full, 0);
        do_alloc(1'b1, 4'd8, 1'b1, 16'h0704, 3'd0, 1'b1, 16'h0, 3'd0);
        alu_fu_free = 1'b1;
        #1;
        chk("R2 ld_full after two", ld_full, 1);
        chk("R2 no ALU dispatch of loads", alu_go, 0);
        ld_fu_free = 1'b1;
        #1;
        chk("R2 load dispatched", ld_go, 1);
        chk("R2 load op", ld_go_op, 7);
        chk("R3 load base value", ld_go_a, 16'h0700);
        @(negedge clk);
        #1;
        chk("R2 second load op", ld_go_op, 8);
        @(negedge clk);
        alu_fu_free = 1'b0;
        ld_fu_free  = 1'b0;

        // R6: ready slot held while unit busy
        do_alloc(1'b0, 4'd11, 1'b1, 16'h0, 3'd0, 1'b1, 16'h0, 3'd0);
        #1;
        chk("R6 no go while unit busy", alu_go, 0);
        @(negedge clk);
        #1;
        chk("R6 still no go", alu_go, 0);

        // R10: flush with a simultaneous allocation
        do_alloc(1'b0, 4'd12, 1'b1, 16'h0, 3'd0, 1'b1, 16'h0, 3'd0);
        do_alloc(1'b1, 4'd13, 1'b1, 16'h0, 3'd0, 1'b1, 16'h0, 3'd0);
        flush       = 1'b1;
        alloc_valid = 1'b1;
        alloc_cls   = 1'b1;
        alloc_op    = 4'd14;
        alu_fu_free = 1'b1;
        ld_fu_free  = 1'b1;
        #1;
        chk("R10 no ALU go during flush", alu_go, 0);
        chk("R10 no load go during flush", ld_go, 0);
        @(negedge clk);
        flush       = 1'b0;
        alloc_valid = 1'b0;
        #1;
        chk("R10 alu_full cleared", alu_full, 0);
        chk("R10 ld_full cleared", ld_full, 0);
        chk("R10 ALU empty after flush", alu_go, 0);
        chk("R10 load dropped during flush", ld_go, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule